// File: doc/BRIEF.md
# I2C Master SCL Clock Generator (Standard and Fast-mode Plus)

This block produces the SCL waveform of an I2C master from a fast system clock. Software-visible settings arrive through a simple write port. In standard timing, a programmable prescaler turns the system clock into an internal tick, and a coarse divider counts ticks for each half of the period. In Fast-mode Plus timing, the prescaler is skipped. Independent high, low and mask counts then set each half directly in system clock cycles.

The SCL pin is driven open-drain. The output `scl_oe` pulls the line low when it is 1. The sensed line `scl_i` feeds back into the high phase. The high count does not start until the line is actually seen high, which absorbs rise time and any clock stretching by a slave. Two one-cycle strobes mark the moments for sampling and for driving data. A configuration check flags settings that would run the internal tick above its limit, or that violate the ordering rule for the mask count.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `rst` is high, `scl_oe`, `rise_stb`, `fall_stb` and `cfg_err` are 0. All setting registers clear to zero.
- R2: While `gen_en` is low, SCL is released (`scl_oe` = 0) one cycle later and no strobe is produced.
- R3: Standard timing (mode bit 7 = 0, bit 2 = 0). The register at 0x14 holds the prescale value in bits [2:0] and the coarse divider in bits [8:3]. Each phase lasts (10 + 4*coarse) * (1 + prescale) clock cycles, so the full period is 20 + 8*coarse ticks. The low phase counts from the cycle `scl_oe` rises. The high phase counts from the first cycle the line is sensed high.
- R4: With mode bit 2 = 1 in standard timing, the prescaler is bypassed and the tick equals the clock.
- R5: Fast-mode Plus (mode register 0x28 bit 7 = 1; mask at 0x2C, high at 0x30, low at 0x34). The low phase lasts 4 + mask + low cycles. The high phase lasts 4 + mask + high cycles. The period is therefore 8 + 2*mask + low + high.
- R6: In Fast-mode Plus, mode bit 1 = 0 makes the high phase use the low count. Mode bit 0 = 0 drops the mask term from both phases.
- R7: The high phase does not advance until `scl_i` is sampled high. Once it has been seen high, later low samples within that phase are ignored.
- R8: A register write changes the waveform only from the next period, which starts with the low phase. A write in the boundary cycle itself applies one period later.
- R9: `fall_stb` is high for exactly the cycle in which `scl_oe` first goes to 1. `rise_stb` is high for one cycle, the cycle after the line is first sampled high in a high phase. The two strobes are never high together.
- R10: `cfg_err` is registered one cycle after the settings. It is 1 in either of two cases. The first is standard timing with a tick above TICK_MAX_HZ: CLK_HZ/(1+prescale), or CLK_HZ when bypassed. The second is Fast-mode Plus with the mask enabled and the mask count not smaller than both the low count and the effective high count.
- R11: When `gen_en` is first sampled high, the first low phase starts in the next cycle, using the registers as they stand at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register byte offset |
| wr_data | input | 10 | Register write data |
| gen_en | input | 1 | Run the SCL generator |
| scl_i | input | 1 | Sensed SCL line level (synchronous) |
| scl_oe | output | 1 | 1 pulls SCL low |
| rise_stb | output | 1 | One-cycle strobe after SCL is seen rising |
| fall_stb | output | 1 | One-cycle strobe on SCL falling |
| cfg_err | output | 1 | Current settings break a timing limit |

## Verification
A register write can land in the same cycle as a period boundary. The block must then finish the boundary with the old settings and pick up the new ones only at the following boundary. The bench provokes this by sweeping the time of a write across a whole Fast-mode Plus period, one cycle at a time. A second case is a stretch release that coincides with the end of the low count. A behavioural model tracks the remaining clocks per phase and compares the SCL enable, both strobes and the error flag every cycle, so an early or late switch shows up as a mismatch.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  // mode register bit positions
  localparam int MB_FMP  = 7;
  localparam int MB_BYP  = 2;
  localparam int MB_SEP  = 1;
  localparam int MB_MSK  = 0;
  // register byte offsets
  localparam int OFS_STD  = 'h14;
  localparam int OFS_MODE = 'h28;
  localparam int OFS_MSK  = 'h2C;
  localparam int OFS_HI   = 'h30;
  localparam int OFS_LO   = 'h34;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;
endpackage

// File: rtl/i2c_scl_regs.sv
module i2c_scl_regs #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 10,
  parameter int CDF_W       = 3,
  parameter int SCGD_W      = 6,
  parameter int SMD_W       = 8,
  parameter int HL_W        = 10,
  parameter int CLK_HZ      = 100_000_000,
  parameter int TICK_MAX_HZ = 20_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CDF_W-1:0]  cdf_q,
  output logic [SCGD_W-1:0] scgd_q,
  output logic              fmp_q,
  output logic              byp_q,
  output logic              sep_q,
  output logic              msk_q,
  output logic [SMD_W-1:0]  smd_q,
  output logic [HL_W-1:0]   hi_q,
  output logic [HL_W-1:0]   lo_q,
  output logic              cfg_err
);
  import i2c_scl_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      cdf_q <= '0; scgd_q <= '0;
      fmp_q <= 1'b0; byp_q <= 1'b0; sep_q <= 1'b0; msk_q <= 1'b0;
      smd_q <= '0; hi_q <= '0; lo_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(OFS_STD)) begin
        cdf_q  <= wr_data[CDF_W-1:0];
        scgd_q <= wr_data[CDF_W+SCGD_W-1:CDF_W];
      end
      if (wr_addr == ADDR_W'(OFS_MODE)) begin
        fmp_q <= wr_data[MB_FMP];
        byp_q <= wr_data[MB_BYP];
        sep_q <= wr_data[MB_SEP];
        msk_q <= wr_data[MB_MSK];
      end
      if (wr_addr == ADDR_W'(OFS_MSK)) smd_q <= wr_data[SMD_W-1:0];
      if (wr_addr == ADDR_W'(OFS_HI))  hi_q  <= wr_data[HL_W-1:0];
      if (wr_addr == ADDR_W'(OFS_LO))  lo_q  <= wr_data[HL_W-1:0];
    end
  end

  logic [63:0]     tick_cap;
  logic [HL_W-1:0] hi_eff;
  logic            std_bad, fmp_bad;

  always_comb begin
    tick_cap = byp_q ? 64'(TICK_MAX_HZ)
                     : (64'(cdf_q) + 64'd1) * 64'(TICK_MAX_HZ);
    std_bad  = !fmp_q && (tick_cap < 64'(CLK_HZ));
    hi_eff   = sep_q ? hi_q : lo_q;
    fmp_bad  = fmp_q && msk_q &&
               ((HL_W'(smd_q) >= hi_eff) || (HL_W'(smd_q) >= lo_q));
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= std_bad || fmp_bad;
  end

  assert_tick_fast_R10: assert property (@(posedge clk) disable iff (rst)
    (!fmp_q && !byp_q && cdf_q == '0 && (CLK_HZ > TICK_MAX_HZ)) |=> cfg_err);
  assert_mask_order_R10: assert property (@(posedge clk) disable iff (rst)
    (fmp_q && msk_q && HL_W'(smd_q) >= lo_q) |=> cfg_err);
endmodule

// File: rtl/i2c_scl_len.sv
module i2c_scl_len #(
  parameter int CDF_W  = 3,
  parameter int SCGD_W = 6,
  parameter int SMD_W  = 8,
  parameter int HL_W   = 10,
  parameter int CNT_W  = 12
) (
  input  logic [CDF_W-1:0]  cdf,
  input  logic [SCGD_W-1:0] scgd,
  input  logic              fmp,
  input  logic              byp,
  input  logic              sep,
  input  logic              msk,
  input  logic [SMD_W-1:0]  smd,
  input  logic [HL_W-1:0]   hi,
  input  logic [HL_W-1:0]   lo,
  output logic [CNT_W-1:0]  lo_units,
  output logic [CNT_W-1:0]  hi_units,
  output logic [CDF_W-1:0]  div_m1
);
  logic [CNT_W-1:0] smd_e, std_u;

  always_comb begin
    smd_e = msk ? CNT_W'(smd) : '0;
    std_u = CNT_W'(10) + (CNT_W'(scgd) << 2);
    if (fmp) begin
      lo_units = CNT_W'(4) + smd_e + CNT_W'(lo);
      hi_units = CNT_W'(4) + smd_e + CNT_W'(sep ? hi : lo);
      div_m1   = '0;
    end else begin
      lo_units = std_u;
      hi_units = std_u;
      div_m1   = byp ? '0 : cdf;
    end
  end
endmodule

// File: rtl/i2c_scl_engine.sv
module i2c_scl_engine #(
  parameter int CDF_W = 3,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_en,
  input  logic             scl_i,
  input  logic [CNT_W-1:0] lo_units,
  input  logic [CNT_W-1:0] hi_units,
  input  logic [CDF_W-1:0] div_m1,
  output logic             scl_oe,
  output logic             rise_stb,
  output logic             fall_stb
);
  import i2c_scl_pkg::*;

  phase_t           ph;
  logic [CNT_W-1:0] cnt, hi_sh;
  logic [CDF_W-1:0] pre, div_sh;
  logic             seen;
  logic             adv, hi_run, start;

  always_comb begin
    adv    = (pre == div_sh);
    hi_run = (ph == PH_HIGH) && (scl_i || seen);
    start  = gen_en && ((ph == PH_IDLE) || (hi_run && adv && cnt == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; scl_oe <= 1'b0; rise_stb <= 1'b0; fall_stb <= 1'b0;
      cnt <= '0; hi_sh <= '0; pre <= '0; div_sh <= '0; seen <= 1'b0;
    end else begin
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
      if (!gen_en) begin
        ph <= PH_IDLE; scl_oe <= 1'b0; cnt <= '0; pre <= '0; seen <= 1'b0;
      end else if (start) begin
        ph       <= PH_LOW;
        scl_oe   <= 1'b1;
        fall_stb <= 1'b1;
        cnt      <= lo_units - CNT_W'(1);
        hi_sh    <= hi_units;
        div_sh   <= div_m1;
        pre      <= '0;
        seen     <= 1'b0;
      end else if (ph == PH_LOW) begin
        if (adv) begin
          pre <= '0;
          if (cnt == '0) begin
            ph     <= PH_HIGH;
            scl_oe <= 1'b0;
            cnt    <= hi_sh - CNT_W'(1);
            seen   <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end else begin
          pre <= pre + CDF_W'(1);
        end
      end else if (hi_run) begin
        seen <= 1'b1;
        if (!seen) rise_stb <= 1'b1;
        if (adv) begin
          pre <= '0;
          cnt <= cnt - CNT_W'(1);
        end else begin
          pre <= pre + CDF_W'(1);
        end
      end
    end
  end

  assert_fall_edge_R9: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> (scl_oe && !$past(scl_oe)));
  assert_rise_released_R9: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> !scl_oe);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(rise_stb && fall_stb));
  assert_idle_release_R2: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> (!scl_oe && !rise_stb && !fall_stb));
  assert_stretch_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_HIGH && !seen && !scl_i && gen_en) |=> (!scl_oe && !rise_stb));
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 10,
  parameter int CDF_W       = 3,
  parameter int SCGD_W      = 6,
  parameter int SMD_W       = 8,
  parameter int HL_W        = 10,
  parameter int CLK_HZ      = 100_000_000,
  parameter int TICK_MAX_HZ = 20_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              gen_en,
  input  logic              scl_i,
  output logic              scl_oe,
  output logic              rise_stb,
  output logic              fall_stb,
  output logic              cfg_err
);
  localparam int STD_CW = SCGD_W + 3;
  localparam int FMP_CW = HL_W + 2;
  localparam int CNT_W  = (STD_CW > FMP_CW) ? STD_CW : FMP_CW;

  logic [CDF_W-1:0]  cdf_q, div_m1;
  logic [SCGD_W-1:0] scgd_q;
  logic              fmp_q, byp_q, sep_q, msk_q;
  logic [SMD_W-1:0]  smd_q;
  logic [HL_W-1:0]   hi_q, lo_q;
  logic [CNT_W-1:0]  lo_units, hi_units;

  i2c_scl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CDF_W(CDF_W), .SCGD_W(SCGD_W),
    .SMD_W(SMD_W), .HL_W(HL_W), .CLK_HZ(CLK_HZ), .TICK_MAX_HZ(TICK_MAX_HZ)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cdf_q(cdf_q), .scgd_q(scgd_q), .fmp_q(fmp_q), .byp_q(byp_q),
    .sep_q(sep_q), .msk_q(msk_q), .smd_q(smd_q), .hi_q(hi_q), .lo_q(lo_q),
    .cfg_err(cfg_err)
  );

  i2c_scl_len #(
    .CDF_W(CDF_W), .SCGD_W(SCGD_W), .SMD_W(SMD_W), .HL_W(HL_W), .CNT_W(CNT_W)
  ) len_i (
    .cdf(cdf_q), .scgd(scgd_q), .fmp(fmp_q), .byp(byp_q), .sep(sep_q),
    .msk(msk_q), .smd(smd_q), .hi(hi_q), .lo(lo_q),
    .lo_units(lo_units), .hi_units(hi_units), .div_m1(div_m1)
  );

  i2c_scl_engine #(.CDF_W(CDF_W), .CNT_W(CNT_W)) eng_i (
    .clk(clk), .rst(rst), .gen_en(gen_en), .scl_i(scl_i),
    .lo_units(lo_units), .hi_units(hi_units), .div_m1(div_m1),
    .scl_oe(scl_oe), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );
endmodule

// File: tb/i2c_scl_gen_tb_top.sv
module i2c_scl_gen_tb_top;
  localparam int CLK_HZ = 100_000_000;
  localparam int TMAX   = 20_000_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic       gen_en = 1'b0;
  logic       stretch = 1'b0;
  logic       scl_i;
  logic       scl_oe, rise_stb, fall_stb, cfg_err;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  assign scl_i = !scl_oe && !stretch;

  i2c_scl_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gen_en(gen_en), .scl_i(scl_i), .scl_oe(scl_oe), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .cfg_err(cfg_err)
  );

  // behavioural reference model
  int r_cdf, r_scgd, r_smd, r_hi, r_lo;
  bit r_fmp, r_byp, r_sep, r_msk;
  int m_ph, m_rem, m_hi;
  bit m_seen, e_oe, e_rise, e_fall, e_err;
  int lo_c, hi_c, dv, sme, hie;
  bit line, go, bad;

  always @(posedge clk) begin
    if (rst) begin
      r_cdf = 0; r_scgd = 0; r_smd = 0; r_hi = 0; r_lo = 0;
      r_fmp = 0; r_byp = 0; r_sep = 0; r_msk = 0;
      m_ph = 0; m_rem = 0; m_hi = 0; m_seen = 0;
      e_oe = 0; e_rise = 0; e_fall = 0; e_err = 0;
    end else begin
      line = !e_oe && !stretch;
      sme  = r_msk ? r_smd : 0;
      hie  = r_sep ? r_hi : r_lo;
      if (r_fmp) begin
        lo_c = 4 + sme + r_lo;
        hi_c = 4 + sme + hie;
        bad  = r_msk && (r_smd >= hie || r_smd >= r_lo);
      end else begin
        dv   = r_byp ? 1 : r_cdf + 1;
        lo_c = (10 + 4 * r_scgd) * dv;
        hi_c = lo_c;
        bad  = (longint'(CLK_HZ) > longint'(TMAX) * (r_byp ? 1 : r_cdf + 1));
      end
      e_rise = 0; e_fall = 0; go = 0;
      if (!gen_en) begin
        m_ph = 0; e_oe = 0;
      end else begin
        if (m_ph == 0) go = 1;
        else if (m_ph == 1) begin
          m_rem--;
          if (m_rem == 0) begin m_ph = 2; e_oe = 0; m_seen = 0; m_rem = m_hi; end
        end else if (m_seen || line) begin
          if (!m_seen) e_rise = 1;
          m_seen = 1;
          m_rem--;
          if (m_rem == 0) go = 1;
        end
        if (go) begin
          m_ph = 1; e_oe = 1; e_fall = 1; m_rem = lo_c; m_hi = hi_c;
        end
      end
      e_err = bad;
      if (wr_en) begin
        case (wr_addr)
          6'h14: begin r_cdf = int'(wr_data[2:0]); r_scgd = int'(wr_data[8:3]); end
          6'h28: begin r_fmp = wr_data[7]; r_byp = wr_data[2]; r_sep = wr_data[1]; r_msk = wr_data[0]; end
          6'h2C: r_smd = int'(wr_data[7:0]);
          6'h30: r_hi  = int'(wr_data);
          6'h34: r_lo  = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      tests++;
      if (scl_oe !== e_oe || rise_stb !== e_rise || fall_stb !== e_fall || cfg_err !== e_err) begin
        fails++;
        $display("FAIL %s t=%0t oe/rise/fall/err actual %b%b%b%b expected %b%b%b%b",
                 cur_req, $time, scl_oe, rise_stb, fall_stb, cfg_err,
                 e_oe, e_rise, e_fall, e_err);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 10'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual running expected done");
    finish_run();
  end

  initial begin
    idle(4);
    // R1: outputs idle while reset is held
    tests++;
    if (scl_oe !== 0 || rise_stb !== 0 || fall_stb !== 0 || cfg_err !== 0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %b%b%b%b expected 0000",
               scl_oe, rise_stb, fall_stb, cfg_err);
    end
    rst = 1'b0;
    idle(3);

    // R3 standard: prescale 4, coarse 0 -> 50 clocks per phase
    cur_req = "R3";
    wr('h14, 4);
    cur_req = "R11";
    gen_en = 1'b1;
    idle(260);
    // R8: coarse 2 written mid-period
    cur_req = "R8";
    wr('h14, (2 << 3) | 4);
    idle(420);

    // R7: stretch at several offsets
    cur_req = "R7";
    for (int k = 0; k < 3; k++) begin
      idle(7 + 19 * k);
      stretch = 1'b1;
      idle(30);
      stretch = 1'b0;
    end
    idle(150);

    // R2: disable mid-period, then restart
    cur_req = "R2";
    gen_en = 1'b0;
    idle(25);
    cur_req = "R11";
    gen_en = 1'b1;
    idle(60);

    // R4 bypass with tick limit broken (R10)
    cur_req = "R4";
    wr('h28, 'h04);
    wr('h14, (1 << 3) | 4);
    idle(200);

    // R5 Fast-mode Plus: mask 2, high 6, low 8
    cur_req = "R5";
    wr('h2C, 2);
    wr('h30, 6);
    wr('h34, 8);
    wr('h28, 'h83);
    idle(200);
    cur_req = "R7";
    idle(5);
    stretch = 1'b1; idle(9); stretch = 1'b0;
    idle(80);

    // R6 variants
    cur_req = "R6";
    wr('h28, 'h80);
    idle(120);
    wr('h28, 'h81);
    idle(120);

    // R8 boundary sweep of a write across a full period
    cur_req = "R8";
    wr('h28, 'h83);
    for (int k = 0; k < 30; k++) begin
      wr('h34, 8 + (k % 3));
      idle(k % 7);
    end
    idle(100);

    // R9 strobes across a long standard run
    cur_req = "R9";
    wr('h28, 0);
    wr('h14, (1 << 3) | 5);
    idle(300);

    // R10 error cases
    cur_req = "R10";
    wr('h14, 3);
    idle(20);
    wr('h14, 5);
    idle(20);
    wr('h28, 'h83);
    wr('h2C, 9);
    idle(60);
    wr('h2C, 1);
    idle(60);
    wr('h28, 'h04);
    idle(20);
    wr('h28, 0);
    idle(40);

    gen_en = 1'b0;
    idle(5);
    finish_run();
  end
endmodule